// File: doc/BRIEF.md
# Slotted Carrier-Sense MAC Controller

This block is the per-node access controller for a single broadcast channel that every node on the chip shares, with all nodes stepping on the same system clock. Time on the channel is cut into slots of one clock cycle. A packet handed over by the network interface is either short (one flit, one slot) or long (four flits, four slots). The controller listens to the channel and starts its packet only at a slot boundary, and only when no other transmission will still occupy the next slot. When the channel is occupied it does not keep waiting. It draws a random delay instead and senses the channel again when that delay runs out.

Collisions can only occur in the first slot of a transmission. Every receiver that sees two headers overlap raises a shared collision tone, which is the wired-OR of all the receivers. If the tone is present in the node's first slot, the node cancels the packet at once. It then waits a random number of slots, with the range doubling on each collision up to a cap, and tries again. A packet that is still colliding after the permitted number of retries is handed to the wired network plane, and the controller is then free for the next packet. Channel occupancy is tracked by a local counter. A header carrying the long flag loads the counter, and the node's own transmissions load it the same way.

Top module: `slot_csma_mac`

## Requirements
- R1: While reset is held, `pkt_ready` is 1 and `tx_start`, `tx_abort`, `tx_done` and `divert` are all 0.
- R2: A packet is accepted only in a cycle where `pkt_ready` and `pkt_valid` are both 1. `pkt_ready` stays 0 from that acceptance until the packet completes or is diverted. A `pkt_valid` raised during that time is not taken.
- R3: When the channel is free, `tx_start` rises in the second cycle after the accepting edge and lasts exactly one cycle, the first slot.
- R4: If `nack` is 0 in the first slot, `tx_done` pulses for one cycle right after the last slot of the packet. For a short packet (`pkt_long` = 0) that is the cycle after `tx_start`. For a long packet (`pkt_long` = 1) it is four cycles after `tx_start`.
- R5: If `nack` is 1 in the first slot, `tx_abort` pulses in the next cycle and no `tx_done` follows for that attempt.
- R6: A foreign header (`hdr_seen` = 1) with `hdr_long` = 1 and `nack` = 0 blocks any start in the three slots that follow it. A short foreign header, or one that coincides with `nack` = 1, leaves the next slot free.
- R7: After the n-th collision, the gap from the cycle showing `tx_abort` to the next `tx_start` cycle is between 2 and 2^min(n+1,K)+1 cycles, where K is `BO_TRUNC` (default 3).
- R8: On the collision that follows `MAX_RETRY` (default 8) retries, which is the ninth attempt, `divert` pulses together with `tx_abort`, and `pkt_ready` is 1 in the next cycle.
- R9: `nack` during the body slots of the node's own long packet has no effect: the packet still ends with `tx_done` on time and no `tx_abort` is produced.
- R10: At most one of `tx_start`, `tx_abort` and `tx_done` is 1 in any cycle, and `divert` is never 1 without `tx_abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle is one slot |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Interface offers a packet |
| pkt_long | input | 1 | Length tag of the offered packet: 1 = four flits, 0 = one flit |
| pkt_ready | output | 1 | Controller can take a packet this cycle |
| hdr_seen | input | 1 | A foreign transmission's header is on the channel this slot |
| hdr_long | input | 1 | Length flag carried in that header: 1 = long |
| nack | input | 1 | Wired-OR collision tone sampled at the end of the slot |
| tx_start | output | 1 | High during the first slot of an own transmission |
| tx_abort | output | 1 | One-cycle pulse: the attempt just made collided and is cancelled |
| tx_done | output | 1 | One-cycle pulse: the packet finished on the channel |
| divert | output | 1 | One-cycle pulse: packet handed to the alternate plane |

## Verification
The checker takes for granted that `hdr_seen` marks only the first slot of some other node's transmission, and that `nack` is raised only in a slot where a header meets another header. It also assumes that a length tag is held steady while `pkt_valid` is being accepted. The bench raises `nack` from its own view of `tx_start` or in step with a header it drives, so each collision lands in a genuine first slot. The one exception is the body-slot test, where the tone is deliberately raised out of place to show that the controller ignores it. Foreign headers are injected only while the controller is sensing, so the three-slot blocking window and its short-header and collided-header exceptions can be observed cleanly at the outputs.

// File: rtl/scm_pkg.sv
package scm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SENSE   = 3'd1,
    ST_FIRST   = 3'd2,
    ST_BODY    = 3'd3,
    ST_BACKOFF = 3'd4
  } scm_state_e;

endpackage

// File: rtl/scm_lfsr.sv
module scm_lfsr #(
  parameter int                 W     = 16,
  parameter int                 OUT_W = 3,
  parameter logic [W-1:0]       TAPS  = 16'hB400,
  parameter logic [W-1:0]       SEED  = 16'h1ACE
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);

  logic [W-1:0] state_q;

  // Galois form, stepping every slot so draws differ between backoffs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else begin
      state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
    end
  end

  assign rnd = state_q[OUT_W-1:0];

endmodule

// File: rtl/scm_busy_track.sv
module scm_busy_track #(
  parameter int LONG_SLOTS = 4,
  parameter int CNT_W      = (LONG_SLOTS > 2) ? $clog2(LONG_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_any,
  input  logic             hdr_is_long,
  input  logic             nack,
  output logic [CNT_W-1:0] remain,
  output logic             next_busy
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(LONG_SLOTS - 1);

  logic [CNT_W-1:0] cnt_q;

  // a header that survives its first slot occupies the slots after it;
  // a collided header frees the channel at once
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (hdr_any) begin
      cnt_q <= (hdr_is_long && !nack) ? LOAD_VAL : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign remain    = cnt_q;
  assign next_busy = (hdr_any && hdr_is_long && !nack) || (cnt_q > CNT_W'(1));

endmodule

// File: rtl/scm_backoff.sv
module scm_backoff #(
  parameter int TRUNC = 3,
  parameter int ATT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ATT_W-1:0] attempt,
  input  logic [TRUNC-1:0] rnd,
  output logic             expired
);

  logic [TRUNC-1:0] mask;
  logic [TRUNC-1:0] cnt_q;

  // mask bit g set when attempt > g: width of window is min(attempt, TRUNC)
  for (genvar g = 0; g < TRUNC; g++) begin : g_mask
    assign mask[g] = (int'(attempt) > g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= rnd & mask;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/slot_csma_mac.sv
module slot_csma_mac
  import scm_pkg::*;
#(
  parameter int              LONG_SLOTS = 4,
  parameter int              MAX_RETRY  = 8,
  parameter int              BO_TRUNC   = 3,
  parameter int              LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h1ACE
) (
  input  logic clk,
  input  logic rst,
  input  logic pkt_valid,
  input  logic pkt_long,
  output logic pkt_ready,
  input  logic hdr_seen,
  input  logic hdr_long,
  input  logic nack,
  output logic tx_start,
  output logic tx_abort,
  output logic tx_done,
  output logic divert
);

  localparam int RETRY_W = $clog2(MAX_RETRY + 1);
  localparam int ATT_W   = RETRY_W + 1;
  localparam int BUSY_W  = (LONG_SLOTS > 2) ? $clog2(LONG_SLOTS) : 1;

  scm_state_e         state_q, state_d;
  logic               cur_long;
  logic [RETRY_W-1:0] retries_q;

  logic               start_d, abort_d, done_d, divert_d;
  logic               bo_load, retry_inc, accept;
  logic [ATT_W-1:0]   bo_attempt;

  logic               own_first;
  logic               hdr_any, hdr_is_long;
  logic [BUSY_W-1:0]  busy_remain;
  logic               next_busy;
  logic [BO_TRUNC-1:0] rnd;
  logic               bo_expired;

  assign own_first   = (state_q == ST_FIRST);
  assign hdr_any     = hdr_seen | own_first;
  assign hdr_is_long = own_first ? cur_long : hdr_long;

  scm_lfsr #(
    .W     (LFSR_W),
    .OUT_W (BO_TRUNC),
    .TAPS  (LFSR_TAPS),
    .SEED  (LFSR_SEED)
  ) u_lfsr (
    .clk (clk),
    .rst (rst),
    .rnd (rnd)
  );

  scm_busy_track #(
    .LONG_SLOTS (LONG_SLOTS),
    .CNT_W      (BUSY_W)
  ) u_busy (
    .clk         (clk),
    .rst         (rst),
    .hdr_any     (hdr_any),
    .hdr_is_long (hdr_is_long),
    .nack        (nack),
    .remain      (busy_remain),
    .next_busy   (next_busy)
  );

  scm_backoff #(
    .TRUNC (BO_TRUNC),
    .ATT_W (ATT_W)
  ) u_bo (
    .clk     (clk),
    .rst     (rst),
    .load    (bo_load),
    .attempt (bo_attempt),
    .rnd     (rnd),
    .expired (bo_expired)
  );

  assign pkt_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    start_d    = 1'b0;
    abort_d    = 1'b0;
    done_d     = 1'b0;
    divert_d   = 1'b0;
    bo_load    = 1'b0;
    retry_inc  = 1'b0;
    accept     = 1'b0;
    bo_attempt = ATT_W'(retries_q) + ATT_W'(1);
    unique case (state_q)
      ST_IDLE: begin
        if (pkt_valid) begin
          accept  = 1'b1;
          state_d = ST_SENSE;
        end
      end
      ST_SENSE: begin
        if (next_busy) begin
          bo_load = 1'b1;
          state_d = ST_BACKOFF;
        end else begin
          start_d = 1'b1;
          state_d = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (nack) begin
          abort_d = 1'b1;
          if (retries_q == RETRY_W'(MAX_RETRY)) begin
            divert_d = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            retry_inc  = 1'b1;
            bo_load    = 1'b1;
            bo_attempt = ATT_W'(retries_q) + ATT_W'(2);
            state_d    = ST_BACKOFF;
          end
        end else if (!cur_long) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_BODY;
        end
      end
      ST_BODY: begin
        if (busy_remain == BUSY_W'(1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (bo_expired) begin
          state_d = ST_SENSE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_long  <= 1'b0;
      retries_q <= '0;
      tx_start  <= 1'b0;
      tx_abort  <= 1'b0;
      tx_done   <= 1'b0;
      divert    <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_start <= start_d;
      tx_abort <= abort_d;
      tx_done  <= done_d;
      divert   <= divert_d;
      if (accept) begin
        cur_long  <= pkt_long;
        retries_q <= '0;
      end else if (retry_inc) begin
        retries_q <= retries_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scm_checker.sv
module scm_checker (
  input logic clk,
  input logic rst,
  input logic pkt_ready,
  input logic hdr_seen,
  input logic hdr_long,
  input logic nack,
  input logic tx_start,
  input logic tx_abort,
  input logic tx_done,
  input logic divert,
  input logic cur_long
);

  a_r3_start_one_slot: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  a_r5_nack_cancels: assert property (@(posedge clk) disable iff (rst)
    (tx_start && nack) |=> (tx_abort && !tx_done));

  a_r4_short_completes: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !nack && !cur_long) |=> tx_done);

  a_r6_long_header_blocks: assert property (@(posedge clk) disable iff (rst)
    (hdr_seen && hdr_long && !nack) |=> !tx_start);

  a_r10_exclusive_pulses: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_start, tx_abort, tx_done}));

  a_r10_divert_needs_abort: assert property (@(posedge clk) disable iff (rst)
    divert |-> tx_abort);

  a_r8_divert_frees: assert property (@(posedge clk) disable iff (rst)
    divert |=> pkt_ready);

  a_r2_ready_means_quiet: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> !tx_start);

endmodule

bind slot_csma_mac scm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .pkt_ready (pkt_ready),
  .hdr_seen  (hdr_seen),
  .hdr_long  (hdr_long),
  .nack      (nack),
  .tx_start  (tx_start),
  .tx_abort  (tx_abort),
  .tx_done   (tx_done),
  .divert    (divert),
  .cur_long  (cur_long)
);

// File: tb/slot_csma_mac_tb.sv
module slot_csma_mac_tb;

  localparam int MAX_RETRY = 8;
  localparam int TRUNC     = 3;

  logic clk = 1'b0;
  logic rst;
  logic pkt_valid, pkt_long, pkt_ready;
  logic hdr_seen, hdr_long, nack;
  logic tx_start, tx_abort, tx_done, divert;
  logic nack_force, nack_manual;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  assign nack = (nack_force & tx_start) | nack_manual;

  slot_csma_mac #(
    .LONG_SLOTS (4),
    .MAX_RETRY  (MAX_RETRY),
    .BO_TRUNC   (TRUNC)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .pkt_long  (pkt_long),
    .pkt_ready (pkt_ready),
    .hdr_seen  (hdr_seen),
    .hdr_long  (hdr_long),
    .nack      (nack),
    .tx_start  (tx_start),
    .tx_abort  (tx_abort),
    .tx_done   (tx_done),
    .divert    (divert)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // R1: reset values
  task automatic t_reset();
    rst = 1'b1;
    pkt_valid = 0; pkt_long = 0; hdr_seen = 0; hdr_long = 0;
    nack_force = 0; nack_manual = 0;
    repeat (3) @(negedge clk);
    chk(pkt_ready == 1'b1, "R1 pkt_ready in reset", int'(pkt_ready), 1);
    chk({tx_start, tx_abort, tx_done, divert} == 4'b0, "R1 outputs in reset",
        int'({tx_start, tx_abort, tx_done, divert}), 0);
    rst = 1'b0;
  endtask

  // R2 R3 R4: short packet on a free channel
  task automatic t_short_free();
    @(negedge clk);
    chk(pkt_ready, "R2 ready before offer", int'(pkt_ready), 1);
    pkt_valid = 1; pkt_long = 0;
    @(negedge clk);
    pkt_valid = 0;
    chk(!pkt_ready, "R2 ready drops after accept", int'(pkt_ready), 0);
    chk(!tx_start, "R3 no start in sense cycle", int'(tx_start), 0);
    @(negedge clk);
    chk(tx_start, "R3 start second cycle", int'(tx_start), 1);
    @(negedge clk);
    chk(!tx_start, "R3 start lasts one slot", int'(tx_start), 0);
    chk(tx_done, "R4 short done after one slot", int'(tx_done), 1);
    @(negedge clk);
    chk(pkt_ready, "R2 ready after done", int'(pkt_ready), 1);
  endtask

  // R4 R9 R2: long packet, tone in body slots, offer while busy
  task automatic t_long_body_nack();
    @(negedge clk);
    pkt_valid = 1; pkt_long = 1;
    @(negedge clk);
    pkt_valid = 0;
    @(negedge clk);
    chk(tx_start, "R3 long start second cycle", int'(tx_start), 1);
    pkt_valid = 1; pkt_long = 0;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      if (i == 1) nack_manual = 1;
      if (i == 3) pkt_valid = 0;
      chk(!tx_done && !tx_abort, "R9 body slot quiet", int'({tx_done, tx_abort}), 0);
      chk(!pkt_ready, "R2 not ready in body", int'(pkt_ready), 0);
    end
    @(negedge clk);
    nack_manual = 0;
    chk(tx_done, "R4 long done four cycles after start", int'(tx_done), 1);
    chk(!tx_abort, "R9 no abort from body tone", int'(tx_abort), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!tx_start, "R2 offer during body not taken", int'(tx_start), 0);
    end
  endtask

  // R6: foreign header while sensing
  task automatic t_foreign(input bit is_long, input bit with_nack, input bit immediate);
    int first_start;
    @(negedge clk);
    pkt_valid = 1; pkt_long = 0;
    @(negedge clk);
    pkt_valid = 0;
    hdr_seen = 1; hdr_long = is_long; nack_manual = with_nack;
    @(negedge clk);
    hdr_seen = 0; hdr_long = 0; nack_manual = 0;
    chk(tx_start == immediate, "R6 start after foreign header", int'(tx_start), int'(immediate));
    if (!immediate) begin
      first_start = 0;
      for (int idx = 3; idx <= 30; idx++) begin
        @(negedge clk);
        if (tx_start) begin
          first_start = idx;
          break;
        end
      end
      chk(first_start >= 5, "R6 no start within busy window", first_start, 5);
    end
    @(negedge clk);
    chk(tx_done, "R4 done after deferred start", int'(tx_done), 1);
    @(negedge clk);
  endtask

  // R5 R7 R8 R10: every attempt collides until divert
  task automatic t_divert();
    int starts = 0, aborts = 0, dones = 0;
    int last_start = 0, last_abort = 0, bound, gap, e;
    bit diverted = 0;
    nack_force = 1;
    @(negedge clk);
    pkt_valid = 1; pkt_long = 1;
    @(negedge clk);
    pkt_valid = 0;
    for (int idx = 2; idx <= 600; idx++) begin
      @(negedge clk);
      if (tx_done) dones++;
      if (tx_start) begin
        if (aborts > 0) begin
          e = (aborts + 1 < TRUNC) ? aborts + 1 : TRUNC;
          bound = (1 << e) + 1;
          gap = idx - last_abort;
          chk(gap >= 2 && gap <= bound, "R7 backoff gap in window", gap, bound);
        end
        starts++;
        last_start = idx;
      end
      if (tx_abort) begin
        aborts++;
        last_abort = idx;
        chk(idx == last_start + 1, "R5 abort right after first slot", idx, last_start + 1);
      end
      if (divert) begin
        chk(tx_abort, "R10 divert with abort", int'(tx_abort), 1);
        chk(aborts == MAX_RETRY + 1, "R8 divert after retry limit", aborts, MAX_RETRY + 1);
        diverted = 1;
        break;
      end
    end
    nack_force = 0;
    chk(diverted, "R8 divert reached", int'(diverted), 1);
    chk(starts == MAX_RETRY + 1, "R8 attempt count", starts, MAX_RETRY + 1);
    chk(dones == 0, "R5 no done after collisions", dones, 0);
    @(negedge clk);
    chk(pkt_ready, "R8 ready after divert", int'(pkt_ready), 1);
    chk(!divert, "R8 divert one cycle", int'(divert), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    report();
    $finish;
  end

  initial begin
    t_reset();
    t_short_free();
    t_long_body_nack();
    t_foreign(1'b0, 1'b0, 1'b1);
    t_foreign(1'b1, 1'b1, 1'b1);
    t_foreign(1'b1, 1'b0, 1'b0);
    t_divert();
    t_short_free();
    report();
    $finish;
  end

endmodule